// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small nonvolatile serial memory of 1024 bits that an external host reaches over a three-wire synchronous link: a select line, a serial clock and a data input. A data output with a separate output-enable models the tri-state pin. A static strap picks the word size. When the strap is high there are 64 words of 16 bits. When it is low there are 128 words of 8 bits. Both views share the same storage.

The host frames each instruction on the select line. An instruction is a start bit, an opcode, an address and, for the storing commands, a data field. Reads return the addressed word after a leading zero. If the host keeps clocking, the read continues through the following words and wraps at the top of the address space.

Storing and clearing commands are armed by the frame and launched when the select line falls. They then run for a fixed number of system clocks. While such a command runs, reselecting the device shows its progress on the data output. A write-enable latch guards every command that changes memory. The serial pins are oversampled in the system clock domain, so the serial clock must stay well below the system clock.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the data output is released (do_oe=0) and the storing commands are locked. A write sent before an unlock leaves the word at its reset content 0xFFFF and starts no busy phase, so reselecting shows no status.
- R2: A frame is a 1 start bit, a 2-bit opcode and then the address, all sampled on rising SK. The address is 6 bits in 16-bit mode (org_x16=1) and 7 bits in 8-bit mode. Opcode 10 reads. On the rising edge that samples the last address bit, DO is driven with a 0. Each following rising edge presents the next bit of the word, MSB first.
- R3: While CS stays high, a read continues with the next address and wraps from the last address to 0. No leading 0 is inserted between words.
- R4: Opcode 01 followed by a data word stores that word. The old content does not need to be cleared first, so bits may go from 0 to 1.
- R5: Opcode 11 sets the addressed word to all ones.
- R6: Opcode 00 takes its sub-code from the two address MSBs. Sub-code 11 unlocks storing commands and sub-code 00 locks them again. While locked, a write leaves memory unchanged.
- R7: Sub-code 10 sets every word to all ones.
- R8: Sub-code 01, followed by a data word, stores that word at every address.
- R9: In 8-bit mode the data field is 8 bits. The byte at an even address is the upper half, and the byte at an odd address the lower half, of 16-bit word address>>1.
- R10: A storing command starts only if CS falls after its last bit and before the next rising SK. A further rising SK with CS high cancels it.
- R11: Once a storing command has started, CS high drives DO with 0 while busy and 1 when ready. A 1 sampled on DI releases DO on the next falling SK. With CS low, DO is released.
- R12: A command that arrives while busy is ignored, and a start happens only when the device is idle.
- R13: The busy phase lasts exactly PROG_CLKS system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| org_x16 | input | 1 | Word-size strap: 1 = 16-bit words, 0 = 8-bit words |
| cs | input | 1 | Select line, asynchronous to clk |
| sk | input | 1 | Serial clock, asynchronous to clk |
| di | input | 1 | Serial data in |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_out (0 = high impedance) |

## Verification
The assertions check four things on every cycle: DO is released one clock after the synchronised select goes low, a launch happens only when idle and is followed by busy, DO never reports ready while busy, and each busy phase lasts exactly PROG_CLKS clocks. The bench scenarios cover everything that depends on memory content and bit sequences. That includes the leading zero and MSB-first order, sequential wrap without a second leading zero, lock and unlock, the cancel window at the select fall, the bulk commands, and where 8-bit bytes land inside 16-bit words.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ERASE = 2'd1,
    OP_ERAL  = 2'd2,
    OP_WRAL  = 2'd3
  } mw_op_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_ARMED, ST_READ, ST_SKIP
  } mw_state_t;

  localparam logic [1:0] CMD_READ  = 2'b10;
  localparam logic [1:0] CMD_WRITE = 2'b01;
  localparam logic [1:0] CMD_ERASE = 2'b11;
  localparam logic [1:0] EXT_WEN   = 2'b11;
  localparam logic [1:0] EXT_WDIS  = 2'b00;
  localparam logic [1:0] EXT_ERAL  = 2'b10;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_be,
  input  logic [WORD_W-1:0] wr_d
);
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < 2; l++)
        if (wr_be[l]) mem[wr_idx][l*HALF +: HALF] <= wr_d[l*HALF +: HALF];
    end
    if (rd_en) rd_q <= mem[rd_idx];
  end
endmodule

// File: rtl/mw_engine.sv
module mw_engine
  import mw_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int WORD_W    = 16,
  parameter int IDX_W     = 6,
  parameter int AW        = 7,
  parameter int PROG_CLKS = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mw_op_t            op_i,
  input  logic              org_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [1:0]        wr_be,
  output logic [WORD_W-1:0] wr_d
);
  localparam int CNT_W = $clog2(PROG_CLKS + 1);
  localparam int HALF  = WORD_W / 2;

  logic [CNT_W-1:0]  cnt;
  mw_op_t            op;
  logic              org;
  logic [AW-1:0]     addr;
  logic [WORD_W-1:0] data;
  logic [IDX_W:0]    sweep;
  logic              first;
  logic              bulk;
  logic [WORD_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      op    <= OP_WRITE;
      org   <= 1'b1;
      addr  <= '0;
      data  <= '0;
      sweep <= '0;
      first <= 1'b0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(PROG_CLKS - 1);
      op    <= op_i;
      org   <= org_i;
      addr  <= addr_i;
      data  <= data_i;
      sweep <= '0;
      first <= 1'b1;
    end else if (busy) begin
      first <= 1'b0;
      if (!sweep[IDX_W]) sweep <= sweep + 1'b1;
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_comb begin
    bulk   = (op == OP_ERAL) || (op == OP_WRAL);
    fill   = org ? data : {data[HALF-1:0], data[HALF-1:0]};
    wr_en  = busy && (bulk ? !sweep[IDX_W] : first);
    wr_idx = bulk ? sweep[IDX_W-1:0] : (org ? addr[IDX_W-1:0] : addr[AW-1:1]);
    wr_be  = (bulk || org) ? 2'b11 : (addr[0] ? 2'b01 : 2'b10);
    wr_d   = (op == OP_ERASE || op == OP_ERAL) ? '1 : fill;
  end
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 6,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              org,
  input  logic              cs_s,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              di_s,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_q,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              start,
  output mw_op_t            op,
  output logic [AW-1:0]     op_addr,
  output logic [WORD_W-1:0] op_data,
  output logic              do_out,
  output logic              do_oe
);
  localparam int HALF = WORD_W / 2;
  localparam int RB   = $clog2(WORD_W);
  localparam int HB   = $clog2(HALF);

  mw_state_t         state;
  logic              wen, rd_oe, rd_bit, stat_oe, stat_mode, drop_pend;
  logic [1:0]        opc;
  logic [4:0]        cnt;
  logic [RB-1:0]     rbit;
  logic [AW-1:0]     sreg_addr;
  logic [WORD_W-1:0] sreg_data;

  logic [AW-1:0]     amask, na, na_m, nxt;
  logic [1:0]        sub;
  logic [IDX_W-1:0]  idx_na, idx_nxt;
  logic [4:0]        aw_len, dw_len;
  logic [HALF-1:0]   half_w;
  logic              bitval;

  always_comb begin
    amask   = org ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}};
    na      = {sreg_addr[AW-2:0], di_s};
    na_m    = na & amask;
    nxt     = (sreg_addr + AW'(1)) & amask;
    sub     = org ? na[AW-2:AW-3] : na[AW-1:AW-2];
    idx_na  = org ? na_m[IDX_W-1:0] : na_m[AW-1:1];
    idx_nxt = org ? nxt[IDX_W-1:0]  : nxt[AW-1:1];
    aw_len  = org ? 5'(AW-1) : 5'(AW);
    dw_len  = org ? 5'(WORD_W) : 5'(HALF);
    half_w  = sreg_addr[0] ? rd_q[HALF-1:0] : rd_q[WORD_W-1:HALF];
    bitval  = org ? rd_q[rbit] : half_w[rbit[HB-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  wen <= 1'b0;  rd_oe <= 1'b0;  rd_bit <= 1'b0;
      stat_oe <= 1'b0;  stat_mode <= 1'b0;  drop_pend <= 1'b0;
      opc <= '0;  cnt <= '0;  rbit <= '0;  sreg_addr <= '0;  sreg_data <= '0;
      op <= OP_WRITE;  start <= 1'b0;  rd_en <= 1'b0;  rd_idx <= '0;
    end else begin
      start <= 1'b0;
      rd_en <= 1'b0;
      // status path on DO
      if (!cs_s) begin
        stat_oe   <= 1'b0;
        drop_pend <= 1'b0;
      end else begin
        if (cs_rise && stat_mode) stat_oe <= 1'b1;
        if (stat_oe && sk_rise && di_s) drop_pend <= 1'b1;
        if (drop_pend && sk_fall) begin
          stat_oe   <= 1'b0;
          stat_mode <= 1'b0;
          drop_pend <= 1'b0;
        end
      end
      // instruction framing
      if (!cs_s) begin
        rd_oe <= 1'b0;
        state <= ST_IDLE;
        if (state == ST_ARMED && cs_fall && wen) begin
          start     <= 1'b1;
          stat_mode <= 1'b1;
        end
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: if (di_s && !busy) begin
            state <= ST_OPC;  cnt <= '0;  sreg_addr <= '0;
          end
          ST_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == 5'd1) begin state <= ST_ADDR; cnt <= '0; end
            else cnt <= cnt + 5'd1;
          end
          ST_ADDR: begin
            sreg_addr <= na_m;
            cnt       <= cnt + 5'd1;
            if (cnt == aw_len - 5'd1) begin
              cnt <= '0;
              case (opc)
                CMD_READ: begin
                  state <= ST_READ;  rd_oe <= 1'b1;  rd_bit <= 1'b0;
                  rd_en <= 1'b1;     rd_idx <= idx_na;
                  rbit  <= RB'(dw_len - 5'd1);
                end
                CMD_WRITE: begin op <= OP_WRITE; state <= ST_DATA; end
                CMD_ERASE: begin op <= OP_ERASE; state <= ST_ARMED; end
                default: case (sub)
                  EXT_WEN:  begin wen <= 1'b1; state <= ST_SKIP; end
                  EXT_WDIS: begin wen <= 1'b0; state <= ST_SKIP; end
                  EXT_ERAL: begin op <= OP_ERAL; state <= ST_ARMED; end
                  default:  begin op <= OP_WRAL; state <= ST_DATA; end
                endcase
              endcase
            end
          end
          ST_DATA: begin
            sreg_data <= {sreg_data[WORD_W-2:0], di_s};
            if (cnt == dw_len - 5'd1) state <= ST_ARMED;
            else cnt <= cnt + 5'd1;
          end
          ST_ARMED: state <= ST_SKIP;
          ST_READ: begin
            rd_bit <= bitval;
            if (rbit == '0) begin
              rbit      <= RB'(dw_len - 5'd1);
              sreg_addr <= nxt;
              rd_en     <= 1'b1;
              rd_idx    <= idx_nxt;
            end else rbit <= rbit - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign op_addr = sreg_addr;
  assign op_data = sreg_data;
  assign do_oe   = rd_oe | stat_oe;
  assign do_out  = rd_oe ? rd_bit : ~busy;
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int MEM_BITS    = 1024,
  parameter int WORD_W      = 16,
  parameter int PROG_CLKS   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic org_x16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_out,
  output logic do_oe
);
  localparam int DEPTH = MEM_BITS / WORD_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AW    = IDX_W + 1;

  logic [2:0]        pins_s;
  logic              cs_lvl, sk_lvl, di_lvl;
  logic [1:0]        edge_prev;
  logic              cs_rise, cs_fall, sk_rise, sk_fall;
  logic              busy, start_op;
  mw_op_t            op;
  logic [AW-1:0]     op_addr;
  logic [WORD_W-1:0] op_data, rd_q, wr_d;
  logic              rd_en, wr_en;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [1:0]        wr_be;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({cs, sk, di}), .q(pins_s)
  );

  assign {cs_lvl, sk_lvl, di_lvl} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) edge_prev <= 2'b00;
    else     edge_prev <= {cs_lvl, sk_lvl};
  end

  assign cs_rise = cs_lvl & ~edge_prev[1];
  assign cs_fall = ~cs_lvl & edge_prev[1];
  assign sk_rise = sk_lvl & ~edge_prev[0];
  assign sk_fall = ~sk_lvl & edge_prev[0];

  mw_frame #(.WORD_W(WORD_W), .IDX_W(IDX_W), .AW(AW)) u_frame (
    .clk(clk), .rst(rst), .org(org_x16),
    .cs_s(cs_lvl), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .di_s(di_lvl),
    .busy(busy), .rd_q(rd_q), .rd_en(rd_en), .rd_idx(rd_idx),
    .start(start_op), .op(op), .op_addr(op_addr), .op_data(op_data),
    .do_out(do_out), .do_oe(do_oe)
  );

  mw_engine #(.DEPTH(DEPTH), .WORD_W(WORD_W), .IDX_W(IDX_W), .AW(AW),
              .PROG_CLKS(PROG_CLKS)) u_engine (
    .clk(clk), .rst(rst), .start(start_op), .op_i(op), .org_i(org_x16),
    .addr_i(op_addr), .data_i(op_data), .busy(busy),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_d(wr_d)
  );

  mw_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rd_en(rd_en), .rd_idx(rd_idx), .rd_q(rd_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_d(wr_d)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int PROG_CLKS = 200
) (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic busy,
  input logic start_op,
  input logic do_oe,
  input logic do_out
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  a_r11_hiz_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !do_oe);

  a_r12_start_only_idle: assert property (@(posedge clk) disable iff (rst)
    start_op |-> !busy);

  a_r12_start_then_busy: assert property (@(posedge clk) disable iff (rst)
    start_op |=> busy);

  a_r11_busy_shows_zero: assert property (@(posedge clk) disable iff (rst)
    (busy && do_oe) |-> !do_out);

  a_r13_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == 32'(PROG_CLKS)));
endmodule

bind mw_eeprom_slave mw_eeprom_chk #(.PROG_CLKS(PROG_CLKS)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_lvl), .busy(busy),
  .start_op(start_op), .do_oe(do_oe), .do_out(do_out)
);

// File: tb/sim_mw_eeprom_slave.sv
module sim_mw_eeprom_slave;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst, org, cs, sk, di;
  logic do_out, do_oe;
  logic last_q, last_oe;
  int   n_chk = 0;
  int   n_err = 0;

  always #5 clk = ~clk;

  mw_eeprom_slave #(.PROG_CLKS(PROG)) u0 (
    .clk(clk), .rst(rst), .org_x16(org), .cs(cs), .sk(sk), .di(di),
    .do_out(do_out), .do_oe(do_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic d);
    sk = 1'b0; di = d; tick(4);
    sk = 1'b1; tick(4);
    last_q = do_out; last_oe = do_oe;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic sel();   sk = 1'b0; cs = 1'b1; tick(4); endtask
  task automatic desel(); sk = 1'b0; cs = 1'b0; di = 1'b0; tick(6); endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  function automatic logic [31:0] hdr(input logic [1:0] opc, input int a);
    return (32'd1 << (aw() + 2)) | (32'(opc) << aw()) | 32'(a);
  endfunction

  function automatic int ext(input logic [1:0] s);
    return int'(s) << (aw() - 2);
  endfunction

  task automatic cmd(input logic [1:0] opc, input int a);
    sel(); send(hdr(opc, a), aw() + 3); desel();
  endtask

  task automatic store(input logic [1:0] opc, input int a, input logic [15:0] d);
    sel(); send(hdr(opc, a), aw() + 3); send(32'(d), dw()); desel();
    tick(PROG + 20);
  endtask

  task automatic read_seq(input string req, input int a, input int n,
                          output logic [15:0] w0, output logic [15:0] w1);
    logic [15:0] w;
    w0 = '0; w1 = '0;
    sel();
    send(hdr(2'b10, a), aw() + 3);
    check({req, " leading zero"}, {last_oe, last_q}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < dw(); b++) begin
        clk_bit(1'b0);
        w = {w[14:0], last_q};
      end
      if (k == 0) w0 = w; else w1 = w;
    end
    desel();
    check({req, " released after read"}, do_oe, 1'b0);
  endtask

  task automatic t_reset();
    logic [15:0] a, b;
    check("R1 released at reset", do_oe, 1'b0);
    store(2'b01, 3, 16'h1234);
    read_seq("R1", 3, 1, a, b);
    check("R1 locked write", a, 16'hFFFF);
    sel(); check("R1 no status after locked write", do_oe, 1'b0); desel();
  endtask

  task automatic t_write_status();
    logic [15:0] a, b;
    cmd(2'b00, ext(2'b11));
    sel(); send(hdr(2'b01, 7), 9); send(32'hA55A, 16); desel();
    sel();
    check("R11 busy shown", {do_oe, do_out}, 2'b10);
    tick(PROG - 40);
    check("R13 still busy", {do_oe, do_out}, 2'b10);
    tick(60);
    check("R13 ready after window", {do_oe, do_out}, 2'b11);
    clk_bit(1'b1);
    sk = 1'b0; tick(4);
    check("R11 released by a 1 on DI", do_oe, 1'b0);
    desel();
    read_seq("R2", 7, 1, a, b);
    check("R4 write", a, 16'hA55A);
    store(2'b01, 7, 16'h0F0F);
    read_seq("R2", 7, 1, a, b);
    check("R4 overwrite no erase", a, 16'h0F0F);
  endtask

  task automatic t_erase();
    logic [15:0] a, b;
    cmd(2'b11, 7); tick(PROG + 20);
    read_seq("R5", 7, 1, a, b);
    check("R5 erase", a, 16'hFFFF);
  endtask

  task automatic t_seq();
    logic [15:0] a, b;
    store(2'b01, 63, 16'h1111);
    store(2'b01, 0, 16'h8001);
    read_seq("R3", 63, 2, a, b);
    check("R3 first word", a, 16'h1111);
    check("R3 wrapped word", b, 16'h8001);
  endtask

  task automatic t_abort();
    logic [15:0] a, b;
    sel(); send(hdr(2'b01, 10), 9); send(32'h5555, 16); clk_bit(1'b0); desel();
    tick(PROG + 20);
    read_seq("R10", 10, 1, a, b);
    check("R10 cancelled write", a, 16'hFFFF);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] a, b;
    sel(); send(hdr(2'b01, 5), 9); send(32'h1234, 16); desel();
    cmd(2'b11, 5);
    tick(PROG + 20);
    read_seq("R12", 5, 1, a, b);
    check("R12 erase during busy ignored", a, 16'h1234);
  endtask

  task automatic t_lock();
    logic [15:0] a, b;
    cmd(2'b00, ext(2'b00));
    store(2'b01, 20, 16'h0000);
    read_seq("R6", 20, 1, a, b);
    check("R6 locked again", a, 16'hFFFF);
    cmd(2'b00, ext(2'b11));
    store(2'b01, 20, 16'h00C3);
    read_seq("R6", 20, 1, a, b);
    check("R6 unlocked again", a, 16'h00C3);
  endtask

  task automatic t_bulk();
    logic [15:0] a, b;
    store(2'b00, ext(2'b01), 16'h6789);
    read_seq("R8", 0, 1, a, b);  check("R8 fill word 0", a, 16'h6789);
    read_seq("R8", 63, 1, a, b); check("R8 fill word 63", a, 16'h6789);
    cmd(2'b00, ext(2'b10)); tick(PROG + 20);
    read_seq("R7", 0, 1, a, b);  check("R7 clear word 0", a, 16'hFFFF);
    read_seq("R7", 40, 1, a, b); check("R7 clear word 40", a, 16'hFFFF);
  endtask

  task automatic t_bytes();
    logic [15:0] a, b;
    org = 1'b0; tick(4);
    store(2'b01, 9, 16'h003C);
    store(2'b01, 127, 16'h005A);
    read_seq("R9", 9, 1, a, b);   check("R9 byte read", a, 16'h003C);
    read_seq("R9", 8, 1, a, b);   check("R9 neighbour byte", a, 16'h00FF);
    read_seq("R9", 127, 2, a, b);
    check("R9 top byte", a, 16'h005A);
    check("R3 byte wrap", b, 16'h00FF);
    org = 1'b1; tick(4);
    read_seq("R9", 4, 1, a, b);   check("R9 odd byte is lower half", a, 16'hFF3C);
    read_seq("R9", 63, 1, a, b);  check("R9 seventh address bit", a, 16'hFF5A);
  endtask

  initial begin
    rst = 1'b1; org = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_write_status();
    t_erase();
    t_seq();
    t_abort();
    t_busy_ignore();
    t_lock();
    t_bulk();
    t_bytes();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule